// File: doc/BRIEF.md
# Precision time-of-day counter

This block keeps a free-running time of day as a 32-bit seconds field and a 31-bit sub-seconds field. On every reference tick it adds a programmable sub-second increment and rolls the sub-seconds over into seconds. The rollover point is chosen by a mode pin. In binary mode the sub-seconds wrap at 2^31, so one count is about 0.4657 ns. In decimal mode they count nanoseconds and wrap after 999,999,999. The current time is always visible on the output pins, so neighbouring logic can capture it. A registered pulse-per-second strobe marks each increment of the seconds field.

Software or a servo loop changes the time through one command stream. A command either loads an absolute time or adds or subtracts a signed offset. The offset is applied with carry or borrow across the boundary between seconds and sub-seconds, and seconds wrap modulo 2^32.

The command stream is valid/ready. A transfer happens on a rising clock edge at which both `cmd_valid_i` and `cmd_ready_o` are high. After a transfer, `cmd_ready_o` stays low for exactly one cycle while the command waits to be applied. A source that sees `cmd_ready_o` low must hold its command or drop it. Whatever is on the command pins during that cycle is not taken.

Top module: `tod_counter`

## Requirements
- R1: After reset the seconds and sub-seconds outputs are 0, `cmd_ready_o` is 1, and `done_o` and `pps_o` are 0.
- R2: At each clock edge with `tick_i` high and no command being applied, the sub-seconds advance by `incr_i`. If `incr_i` is at or above the active rollover limit, it is clamped to the limit minus one. With `tick_i` low and no command being applied, the time does not change.
- R3: With `mode_dec_i` = 0 (binary), a sub-second sum of 2^31 or more wraps by subtracting 2^31 and adds one to seconds.
- R4: With `mode_dec_i` = 1 (decimal), a sub-second sum of 1,000,000,000 or more wraps by subtracting 10^9 and adds one to seconds. In this mode the sub-seconds output stays below 10^9.
- R5: A command with `cmd_set_i` = 1 replaces the time with `cmd_sec_i` and `cmd_sub_i`. If `cmd_sub_i` is at or above the active limit, it is clamped to the limit minus one.
- R6: A command with `cmd_set_i` = 0 and `cmd_neg_i` = 0 adds the offset to the time. A sub-second sum at or above the limit carries one second.
- R7: A command with `cmd_set_i` = 0 and `cmd_neg_i` = 1 subtracts the offset from the time. A negative sub-second difference borrows one second and adds the limit.
- R8: Seconds arithmetic wraps modulo 2^32 in both directions without any fault indication.
- R9: An offset sub-seconds value at or above the active limit is clamped to the limit minus one before the offset is added or subtracted.
- R10: A command accepted at edge N is applied at edge N+1. Any tick increment at edge N+1 is dropped. `done_o` is high for exactly the one cycle after edge N+1.
- R11: `cmd_ready_o` is low for the cycle after an accepted command. Command inputs presented while `cmd_ready_o` is low have no effect on the time.
- R12: `pps_o` is registered. It is high for one cycle after each edge at which a tick increment carries into seconds, and the new seconds value appears in that same cycle. A set or an offset command never raises `pps_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| tick_i | input | 1 | Reference tick strobe, one increment per high cycle |
| mode_dec_i | input | 1 | 0: binary rollover at 2^31, 1: decimal rollover at 10^9 |
| incr_i | input | 31 | Sub-second increment per tick |
| cmd_valid_i | input | 1 | Command valid |
| cmd_ready_o | output | 1 | Command ready, low while a command is pending |
| cmd_set_i | input | 1 | 1: load absolute time, 0: apply offset |
| cmd_neg_i | input | 1 | Offset direction, 1: subtract, 0: add |
| cmd_sec_i | input | 32 | Command seconds value |
| cmd_sub_i | input | 31 | Command sub-seconds value |
| done_o | output | 1 | One-cycle strobe when a command has been applied |
| sec_o | output | 32 | Current seconds |
| sub_o | output | 31 | Current sub-seconds |
| pps_o | output | 1 | One-cycle pulse on each seconds increment from ticking |

## Verification
Several properties are checked on every cycle:
- the time holds still when there is neither a tick nor a command;
- the decimal sub-seconds stay below 10^9;
- ready drops after each accepted command;
- done follows each pending command and lasts one cycle;
- every PPS pulse coincides with a seconds value one greater than before, and never with a command.

The exact results of offset arithmetic can only be shown by the bench's scenarios. These cover carry, borrow, seconds wrap and clamping in both modes. The bench also shows that a tick during an apply cycle is dropped, that increments are clamped, and that data held during back-pressure is ignored.

// File: rtl/tod_pkg.sv
package tod_pkg;
  parameter int SEC_W = 32;
  parameter int SUB_W = 31;
  parameter int LIM_W = SUB_W + 1;

  typedef struct packed {
    logic             load;
    logic             neg;
    logic [SEC_W-1:0] sec;
    logic [SUB_W-1:0] sub;
  } tod_cmd_t;

  // Saturate a sub-seconds value to one below the active rollover limit.
  function automatic logic [LIM_W-1:0] clamp_sub(input logic [SUB_W-1:0] v,
                                                  input logic [LIM_W-1:0] lim);
    logic [LIM_W-1:0] w;
    w = {1'b0, v};
    return (w >= lim) ? (lim - 1'b1) : w;
  endfunction
endpackage

// File: rtl/tod_step.sv
module tod_step
  import tod_pkg::*;
(
  input  logic [SEC_W-1:0] sec_i,
  input  logic [SUB_W-1:0] sub_i,
  input  logic [SUB_W-1:0] incr_i,
  input  logic [LIM_W-1:0] lim_i,
  output logic [SEC_W-1:0] sec_o,
  output logic [SUB_W-1:0] sub_o,
  output logic             carry_o
);
  logic [LIM_W:0] sum;
  logic [LIM_W:0] wrapped;
  logic           unused_hi;

  always_comb begin
    sum     = {2'b00, sub_i} + {1'b0, clamp_sub(incr_i, lim_i)};
    carry_o = (sum >= {1'b0, lim_i});
    wrapped = carry_o ? (sum - {1'b0, lim_i}) : sum;
    sec_o   = sec_i + SEC_W'(carry_o);
  end

  assign sub_o     = wrapped[SUB_W-1:0];
  assign unused_hi = ^wrapped[LIM_W:SUB_W];
endmodule

// File: rtl/tod_offset.sv
module tod_offset
  import tod_pkg::*;
(
  input  logic [SEC_W-1:0] sec_i,
  input  logic [SUB_W-1:0] sub_i,
  input  logic [SEC_W-1:0] off_sec_i,
  input  logic [SUB_W-1:0] off_sub_i,
  input  logic             neg_i,
  input  logic [LIM_W-1:0] lim_i,
  output logic [SEC_W-1:0] sec_o,
  output logic [SUB_W-1:0] sub_o
);
  logic [LIM_W:0] off_w;
  logic [LIM_W:0] cur_w;
  logic [LIM_W:0] res;
  logic [LIM_W:0] tmp;
  logic           adj;
  logic           unused_hi;

  always_comb begin
    off_w = {1'b0, clamp_sub(off_sub_i, lim_i)};
    cur_w = {2'b00, sub_i};
    if (!neg_i) begin
      tmp   = cur_w + off_w;
      adj   = (tmp >= {1'b0, lim_i});
      res   = adj ? (tmp - {1'b0, lim_i}) : tmp;
      sec_o = sec_i + off_sec_i + SEC_W'(adj);
    end else begin
      tmp   = cur_w + {1'b0, lim_i} - off_w;
      adj   = (cur_w < off_w);
      res   = adj ? tmp : (cur_w - off_w);
      sec_o = sec_i - off_sec_i - SEC_W'(adj);
    end
  end

  assign sub_o     = res[SUB_W-1:0];
  assign unused_hi = ^res[LIM_W:SUB_W];
endmodule

// File: rtl/tod_pps.sv
module tod_pps (
  input  logic clk,
  input  logic rst_n,
  input  logic roll_i,
  output logic pps_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pps_o <= 1'b0;
    else        pps_o <= roll_i;
  end
endmodule

// File: rtl/tod_counter.sv
module tod_counter
  import tod_pkg::*;
#(
  parameter logic [LIM_W-1:0] DEC_LIMIT = 32'd1000000000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             mode_dec_i,
  input  logic [SUB_W-1:0] incr_i,
  input  logic             cmd_valid_i,
  output logic             cmd_ready_o,
  input  logic             cmd_set_i,
  input  logic             cmd_neg_i,
  input  logic [SEC_W-1:0] cmd_sec_i,
  input  logic [SUB_W-1:0] cmd_sub_i,
  output logic             done_o,
  output logic [SEC_W-1:0] sec_o,
  output logic [SUB_W-1:0] sub_o,
  output logic             pps_o
);
  localparam logic [LIM_W-1:0] BIN_LIMIT = LIM_W'(1) << SUB_W;

  logic [LIM_W-1:0] lim;
  logic [SEC_W-1:0] sec_q, step_sec, off_sec;
  logic [SUB_W-1:0] sub_q, step_sub, off_sub;
  logic [LIM_W-1:0] load_sub;
  logic             step_carry;
  logic             pend_q;
  logic             done_q;
  tod_cmd_t         cmd_q;
  logic             unused_load;

  assign lim         = mode_dec_i ? DEC_LIMIT : BIN_LIMIT;
  assign cmd_ready_o = !pend_q;
  assign load_sub    = clamp_sub(cmd_q.sub, lim);
  assign unused_load = load_sub[LIM_W-1];

  tod_step u_step (
    .sec_i  (sec_q),
    .sub_i  (sub_q),
    .incr_i (incr_i),
    .lim_i  (lim),
    .sec_o  (step_sec),
    .sub_o  (step_sub),
    .carry_o(step_carry)
  );

  tod_offset u_offset (
    .sec_i    (sec_q),
    .sub_i    (sub_q),
    .off_sec_i(cmd_q.sec),
    .off_sub_i(cmd_q.sub),
    .neg_i    (cmd_q.neg),
    .lim_i    (lim),
    .sec_o    (off_sec),
    .sub_o    (off_sub)
  );

  tod_pps u_pps (
    .clk   (clk),
    .rst_n (rst_n),
    .roll_i(tick_i && !pend_q && step_carry),
    .pps_o (pps_o)
  );

  // Command slot: one pending entry, applied on the following edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      cmd_q  <= '0;
    end else if (pend_q) begin
      pend_q <= 1'b0;
    end else if (cmd_valid_i) begin
      pend_q <= 1'b1;
      cmd_q  <= '{load: cmd_set_i, neg: cmd_neg_i, sec: cmd_sec_i, sub: cmd_sub_i};
    end
  end

  // Time registers: command beats tick in the same cycle.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sec_q  <= '0;
      sub_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= pend_q;
      if (pend_q) begin
        if (cmd_q.load) begin
          sec_q <= cmd_q.sec;
          sub_q <= load_sub[SUB_W-1:0];
        end else begin
          sec_q <= off_sec;
          sub_q <= off_sub;
        end
      end else if (tick_i) begin
        sec_q <= step_sec;
        sub_q <= step_sub;
      end
    end
  end

  assign sec_o  = sec_q;
  assign sub_o  = sub_q;
  assign done_o = done_q;

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_i && !pend_q) |=> ($stable(sec_q) && $stable(sub_q))); // R2

  AST_DEC_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_dec_i && ({1'b0, sub_q} < DEC_LIMIT)) |=>
      (!mode_dec_i || ({1'b0, sub_q} < DEC_LIMIT))); // R4

  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid_i && cmd_ready_o) |=> !cmd_ready_o); // R11

  AST_DONE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_ready_o |=> done_o); // R10

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R10

  AST_PPS_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    pps_o |-> (sec_q == $past(sec_q) + 1'b1)); // R12

  AST_PPS_NOT_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !pps_o); // R12
endmodule

// File: tb/tod_counter_tb.sv
`timescale 1ns/1ps
module tod_counter_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_i = 1'b0;
  logic        mode_dec_i = 1'b0;
  logic [30:0] incr_i = '0;
  logic        cmd_valid_i = 1'b0;
  logic        cmd_ready_o;
  logic        cmd_set_i = 1'b0;
  logic        cmd_neg_i = 1'b0;
  logic [31:0] cmd_sec_i = '0;
  logic [30:0] cmd_sub_i = '0;
  logic        done_o;
  logic [31:0] sec_o;
  logic [30:0] sub_o;
  logic        pps_o;

  int n_total = 0;
  int n_bad   = 0;

  always #2 clk = ~clk;

  tod_counter u_dut (.*);

  typedef struct packed {
    logic        dec;
    logic [31:0] bsec;
    logic [30:0] bsub;
    logic        neg;
    logic [31:0] osec;
    logic [30:0] osub;
    logic [31:0] esec;
    logic [30:0] esub;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 32'd10, 31'd100, 1'b0, 32'd1, 31'd50, 32'd11, 31'd150},                          // R6 plain add
    '{1'b0, 32'd5, 31'h7FFF_FFF0, 1'b0, 32'd0, 31'h20, 32'd6, 31'h10},                       // R6 R3 carry
    '{1'b0, 32'd5, 31'h10, 1'b1, 32'd1, 31'h20, 32'd3, 31'h7FFF_FFF0},                       // R7 borrow
    '{1'b1, 32'd7, 31'd999999990, 1'b0, 32'd2, 31'd20, 32'd10, 31'd10},                      // R6 R4 carry
    '{1'b1, 32'd7, 31'd5, 1'b1, 32'd0, 31'd10, 32'd6, 31'd999999995},                        // R7 R4 borrow
    '{1'b0, 32'hFFFF_FFFF, 31'h7FFF_FFFF, 1'b0, 32'd0, 31'd1, 32'd0, 31'd0},                 // R8 wrap up
    '{1'b1, 32'd0, 31'd0, 1'b1, 32'd0, 31'd1, 32'hFFFF_FFFF, 31'd999999999},                 // R8 wrap down
    '{1'b1, 32'd1, 31'd0, 1'b0, 32'd0, 31'h7FFF_FFFF, 32'd1, 31'd999999999},                 // R9 clamp add
    '{1'b1, 32'd3, 31'd999999999, 1'b1, 32'd0, 31'd1500000000, 32'd3, 31'd0},                // R9 clamp sub
    '{1'b0, 32'd100, 31'd1000, 1'b1, 32'd99, 31'd1000, 32'd1, 31'd0}                         // R7 no borrow
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_total++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // Drive at negedge; returns at the negedge after the apply edge.
  task automatic do_cmd(input logic s, input logic n, input logic [31:0] se,
                        input logic [30:0] su, output logic dn);
    @(negedge clk);
    cmd_valid_i = 1'b1; cmd_set_i = s; cmd_neg_i = n; cmd_sec_i = se; cmd_sub_i = su;
    @(negedge clk);
    cmd_valid_i = 1'b0;
    @(negedge clk);
    dn = done_o;
  endtask

  task automatic tick_once();
    @(negedge clk); tick_i = 1'b1;
    @(negedge clk); tick_i = 1'b0;
  endtask

  initial begin
    repeat (400000) @(posedge clk);
    n_total++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", n_total, n_bad);
    $finish;
  end

  initial begin
    logic dn;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 sec", sec_o, 0);
    check("R1 sub", {1'b0, sub_o}, 0);
    check("R1 ready", {31'd0, cmd_ready_o}, 1);
    check("R1 done", {31'd0, done_o}, 0);
    check("R1 pps", {31'd0, pps_o}, 0);

    // Offset vectors
    for (int i = 0; i < NV; i++) begin
      mode_dec_i = VECS[i].dec;
      do_cmd(1'b1, 1'b0, VECS[i].bsec, VECS[i].bsub, dn);
      check("R5 base", sec_o, VECS[i].bsec);
      do_cmd(1'b0, VECS[i].neg, VECS[i].osec, VECS[i].osub, dn);
      check("R10 done", {31'd0, dn}, 1);
      check("R6/R7/R8/R9 sec", sec_o, VECS[i].esec);
      check("R6/R7/R8/R9 sub", {1'b0, sub_o}, {1'b0, VECS[i].esub});
      check("R12 no pps on cmd", {31'd0, pps_o}, 0);
      @(negedge clk);
      check("R10 done width", {31'd0, done_o}, 0);
    end

    // Binary increment and rollover
    mode_dec_i = 1'b0;
    do_cmd(1'b1, 1'b0, 32'd0, 31'd0, dn);
    incr_i = 31'h4000_0000;
    tick_once();
    check("R2 sub step", {1'b0, sub_o}, 32'h4000_0000);
    check("R2 sec step", sec_o, 0);
    tick_once();
    check("R3 sec", sec_o, 1);
    check("R3 sub", {1'b0, sub_o}, 0);
    check("R12 pps high", {31'd0, pps_o}, 1);
    @(negedge clk);
    check("R12 pps low", {31'd0, pps_o}, 0);
    repeat (3) @(negedge clk);
    check("R2 hold sec", sec_o, 1);
    check("R2 hold sub", {1'b0, sub_o}, 0);

    // Decimal: clamped increment, then rollover
    mode_dec_i = 1'b1;
    do_cmd(1'b1, 1'b0, 32'd0, 31'd0, dn);
    incr_i = 31'h7FFF_FFFF;
    tick_once();
    check("R2 incr clamp", {1'b0, sub_o}, 32'd999999999);
    incr_i = 31'd40;
    tick_once();
    check("R4 sec", sec_o, 1);
    check("R4 sub", {1'b0, sub_o}, 32'd39);
    check("R12 pps dec", {31'd0, pps_o}, 1);

    // Set clamp
    do_cmd(1'b1, 1'b0, 32'd4, 31'd1200000000, dn);
    check("R5 sec", sec_o, 4);
    check("R5 sub clamp", {1'b0, sub_o}, 32'd999999999);

    // Priority: tick during apply is dropped
    mode_dec_i = 1'b0;
    incr_i = 31'd7;
    tick_i = 1'b1;
    do_cmd(1'b1, 1'b0, 32'd20, 31'd100, dn);
    tick_i = 1'b0;
    check("R10 priority sec", sec_o, 20);
    check("R10 priority sub", {1'b0, sub_o}, 32'd100);
    tick_once();
    check("R2 after cmd", {1'b0, sub_o}, 32'd107);

    // Back-pressure: data held during not-ready is not taken
    @(negedge clk);
    cmd_valid_i = 1'b1; cmd_set_i = 1'b1; cmd_neg_i = 1'b0;
    cmd_sec_i = 32'd50; cmd_sub_i = 31'd0;
    @(negedge clk);
    check("R11 ready low", {31'd0, cmd_ready_o}, 0);
    cmd_sec_i = 32'd99; cmd_sub_i = 31'd5;
    @(negedge clk);
    cmd_valid_i = 1'b0;
    check("R11 first applied", sec_o, 50);
    @(negedge clk);
    check("R11 second ignored sec", sec_o, 50);
    check("R11 second ignored sub", {1'b0, sub_o}, 0);
    check("R11 no second done", {31'd0, done_o}, 0);

    $display("test done: total=%0d bad=%0d", n_total, n_bad);
    $finish;
  end
endmodule